// File: doc/BRIEF.md
# Flash Erase Command Controller

This block is the control logic of a small byte-wide flash array. A host writes a fixed six-cycle command sequence over a parallel bus using an active-low write strobe. The sequence starts either an erase of the whole array or an erase of one sector. Once the sixth cycle is accepted, the block times the erase by itself with an internal cycle counter, so the host does nothing more. When the count runs out, the block sets the affected bytes to 0xFF and goes back to normal reads.

While an erase is running, a read does not return array data. It returns a status byte. Bit 7 of that byte stays 0 until the erase is finished, and bit 6 flips on every read. The host can poll either bit to find when the erase ends.

A boot-lockout input decides whether a whole-array erase may touch the boot sector. The storage is a scaled-down behavioural register array with seven sectors of a few bytes each. The bus strobes are sampled by the block clock. An output-enable flag stands for the bus drive: when the flag is low, the pins are taken as high impedance.

Top module: `flash_erase_ctrl`

## Requirements
- R1: `data_en_o` is 1 only while `oe_ni` is 0 and `rst_ni` is 1. Whenever `data_en_o` is 0, `data_o` is 0x00, and this state stands for high impedance.
- R2: While `rst_ni` is 0, the block is halted and any running erase is abandoned. Every byte returns to its seed value, and after release the block is in read mode.
- R3: Address bits [15:13] select a region. Regions 0–3 are the main sectors, regions 4–5 are the parameter sectors, and regions 6 and 7 are both the boot sector (sector 6). Address bits [1:0] select a byte within the sector. The seed value of byte o in sector s is (s<<4)|o.
- R4: The first five write cycles must be (address[14:0], data) = (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55). A sixth cycle of (0x5555,0x10) starts a chip erase. A sixth cycle with data 0x30 starts a sector erase.
- R5: A cycle that does not match its step returns the sequence to the first step. That cycle is not counted as a first step. A wrong sixth cycle starts nothing.
- R6: The address of a write cycle is taken on the cycle where `we_ni` is first seen low. The data is taken on the cycle where `we_ni` is first seen high again. So the sector of a sector erase comes from the address present at the fall.
- R7: A sector erase sets every byte of the selected sector to 0xFF and leaves all other sectors unchanged.
- R8: A chip erase with `boot_lock_i`=1 at the sixth cycle sets every byte to 0xFF except the boot sector, which keeps its contents.
- R9: A chip erase with `boot_lock_i`=0 sets every byte of the array to 0xFF.
- R10: The erase stays busy for SEC_CYC clock cycles for a sector erase, or CHIP_CYC cycles (more) for a chip erase, after the sixth cycle. Writes during that time are ignored. After that time, the block returns to read mode on its own.
- R11: While busy, an enabled read returns bit 7 = 0, bits 5:0 = 0, and bit 6 equal to a toggle. The toggle flips on each falling edge of `oe_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also samples the bus strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Write data |
| we_ni | input | 1 | Active-low write strobe |
| oe_ni | input | 1 | Active-low output enable |
| boot_lock_i | input | 1 | Keeps the boot sector out of a chip erase |
| data_o | output | 8 | Read data or erase status |
| data_en_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The hardest case to reach is a sector erase in which the address moves between the falling and rising edges of the sixth write strobe. A dedicated write task does this: it drops the strobe with one sector's address, then changes both the address and the data before raising the strobe. The bench then checks that only the sector seen at the fall was erased. A second hard case is an erase cut off by reset partway through. The bench starts an erase, pulls reset a few cycles later, and then checks that reads return seed data and that no delayed erase appears after the old erase time.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int unsigned SECTORS  = 7;
  localparam int unsigned BOOT_SEC = 6;
  localparam int unsigned SEC_W    = 3;
  localparam int unsigned DW       = 8;

  typedef enum logic [1:0] {
    ERASE_NONE   = 2'd0,
    ERASE_SECTOR = 2'd1,
    ERASE_CHIP   = 2'd2
  } erase_kind_e;

  // region 7 folds onto the boot sector
  function automatic logic [SEC_W-1:0] sector_of(logic [2:0] region);
    return (region == 3'd7) ? 3'd6 : region;
  endfunction

  function automatic logic [DW-1:0] seed_byte(int unsigned s, int unsigned o);
    return DW'((s << 4) | (o & 15));
  endfunction
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic                 we_ni,
  input  logic                 busy_i,
  output logic                 start_o,
  output erase_kind_e          kind_o,
  output logic [SEC_W-1:0]     sec_o,
  output logic [2:0]           step_o
);
  localparam logic [14:0] ADDR_A = 15'h5555;
  localparam logic [14:0] ADDR_B = 15'h2AAA;
  localparam logic [2:0]  LAST   = 3'd5;

  logic          we_q;
  logic [AW-1:0] lat_addr_q;
  logic [2:0]    step_q;
  logic          we_fall, we_rise;
  logic          step_hit, chip_hit, sec_hit;

  assign we_fall = we_q && !we_ni;
  assign we_rise = !we_q && we_ni;

  always_comb begin
    unique case (step_q)
      3'd0:    step_hit = (lat_addr_q[14:0] == ADDR_A) && (data_i == 8'hAA);
      3'd1:    step_hit = (lat_addr_q[14:0] == ADDR_B) && (data_i == 8'h55);
      3'd2:    step_hit = (lat_addr_q[14:0] == ADDR_A) && (data_i == 8'h80);
      3'd3:    step_hit = (lat_addr_q[14:0] == ADDR_A) && (data_i == 8'hAA);
      3'd4:    step_hit = (lat_addr_q[14:0] == ADDR_B) && (data_i == 8'h55);
      default: step_hit = 1'b0;
    endcase
  end

  assign chip_hit = (lat_addr_q[14:0] == ADDR_A) && (data_i == 8'h10);
  assign sec_hit  = (data_i == 8'h30);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= 1'b1;
      lat_addr_q <= '0;
      step_q     <= '0;
    end else begin
      we_q <= we_ni;
      if (we_fall) lat_addr_q <= addr_i;
      if (we_rise) begin
        if (busy_i || step_q == LAST || !step_hit) step_q <= '0;
        else                                       step_q <= step_q + 3'd1;
      end
    end
  end

  assign start_o = we_rise && !busy_i && (step_q == LAST) && (chip_hit || sec_hit);
  assign kind_o  = chip_hit ? ERASE_CHIP : ERASE_SECTOR;
  assign sec_o   = sector_of(lat_addr_q[AW-1 -: 3]);
  assign step_o  = step_q;
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer
  import flash_erase_pkg::*;
#(
  parameter int unsigned CHIP_CYC = 200,
  parameter int unsigned SEC_CYC  = 80,
  localparam int unsigned CNT_W   = $clog2(CHIP_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  erase_kind_e        kind_i,
  input  logic [SEC_W-1:0]   sec_i,
  input  logic               lock_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [SECTORS-1:0] mask_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [SECTORS-1:0] mask_d, mask_q;

  for (genvar s = 0; s < SECTORS; s++) begin : g_mask
    if (s == BOOT_SEC) begin : g_boot
      assign mask_d[s] = (kind_i == ERASE_CHIP) ? !lock_i : (sec_i == SEC_W'(s));
    end else begin : g_plain
      assign mask_d[s] = (kind_i == ERASE_CHIP) ? 1'b1 : (sec_i == SEC_W'(s));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q  <= (kind_i == ERASE_CHIP) ? CNT_W'(CHIP_CYC) : CNT_W'(SEC_CYC);
      mask_q <= mask_d;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
  assign mask_o = mask_q;
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_erase_pkg::*;
#(
  parameter int unsigned OFS_W = 2,
  localparam int unsigned WORDS = 1 << OFS_W,
  localparam int unsigned CELLS = SECTORS * WORDS,
  localparam int unsigned IDX_W = $clog2(CELLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               erase_i,
  input  logic [SECTORS-1:0] mask_i,
  input  logic [SEC_W-1:0]   rd_sec_i,
  input  logic [OFS_W-1:0]   rd_ofs_i,
  output logic [DW-1:0]      rd_data_o
);
  logic [CELLS*DW-1:0] flat;
  logic [IDX_W-1:0]    idx;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    for (genvar o = 0; o < WORDS; o++) begin : g_byte
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  cell_q <= seed_byte(s, o);
        else if (erase_i && mask_i[s]) cell_q <= '1;
      end
      assign flat[(s*WORDS+o)*DW +: DW] = cell_q;
    end
  end

  assign idx       = IDX_W'(rd_sec_i) * IDX_W'(WORDS) + IDX_W'(rd_ofs_i);
  assign rd_data_o = flat[idx*DW +: DW];
endmodule

// File: rtl/flash_status_rd.sv
module flash_status_rd
  import flash_erase_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oe_ni,
  input  logic          busy_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_en_o,
  output logic          rd_evt_o,
  output logic          tog_o
);
  logic oe_q, tog_q;

  assign rd_evt_o = oe_q && !oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b1;
      tog_q <= 1'b0;
    end else begin
      oe_q <= oe_ni;
      if (rd_evt_o && busy_i) tog_q <= !tog_q;
    end
  end

  assign data_en_o = rst_ni && !oe_ni;
  assign tog_o     = tog_q;

  always_comb begin
    if (!data_en_o)  data_o = '0;
    else if (busy_i) data_o = {1'b0, tog_q, 6'b0};
    else             data_o = arr_data_i;
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned OFS_W    = 2,
  parameter int unsigned CHIP_CYC = 200,
  parameter int unsigned SEC_CYC  = 80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          boot_lock_i,
  output logic [7:0]    data_o,
  output logic          data_en_o
);
  logic               start;
  erase_kind_e        kind;
  logic [SEC_W-1:0]   sec;
  logic [2:0]         step;
  logic               busy, done;
  logic [SECTORS-1:0] mask;
  logic [DW-1:0]      arr_data;
  logic               rd_evt, tog;

  flash_cmd_seq #(.AW(AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .we_ni   (we_ni),
    .busy_i  (busy),
    .start_o (start),
    .kind_o  (kind),
    .sec_o   (sec),
    .step_o  (step)
  );

  flash_erase_timer #(.CHIP_CYC(CHIP_CYC), .SEC_CYC(SEC_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .kind_i  (kind),
    .sec_i   (sec),
    .lock_i  (boot_lock_i),
    .busy_o  (busy),
    .done_o  (done),
    .mask_o  (mask)
  );

  flash_array #(.OFS_W(OFS_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .erase_i   (done),
    .mask_i    (mask),
    .rd_sec_i  (sector_of(addr_i[AW-1 -: 3])),
    .rd_ofs_i  (addr_i[OFS_W-1:0]),
    .rd_data_o (arr_data)
  );

  flash_status_rd u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oe_ni      (oe_ni),
    .busy_i     (busy),
    .arr_data_i (arr_data),
    .data_o     (data_o),
    .data_en_o  (data_en_o),
    .rd_evt_o   (rd_evt),
    .tog_o      (tog)
  );
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk
  import flash_erase_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               oe_ni,
  input logic               boot_lock_i,
  input logic               data_en_o,
  input logic [7:0]         data_o,
  input logic               start,
  input erase_kind_e        kind,
  input logic [2:0]         step,
  input logic               busy,
  input logic               done,
  input logic [SECTORS-1:0] mask,
  input logic               rd_evt,
  input logic               tog
);
  assert_en_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> !oe_ni);

  assert_step_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= 3'd5);

  assert_boot_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && kind == ERASE_CHIP && boot_lock_i) |=> !mask[BOOT_SEC]);

  assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !start);

  assert_done_in_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> busy);

  assert_poll_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && data_en_o) |-> (data_o[7] == 1'b0));

  assert_toggle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_evt) |=> (tog != $past(tog)));
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oe_ni       (oe_ni),
  .boot_lock_i (boot_lock_i),
  .data_en_o   (data_en_o),
  .data_o      (data_o),
  .start       (start),
  .kind        (kind),
  .step        (step),
  .busy        (busy),
  .done        (done),
  .mask        (mask),
  .rd_evt      (rd_evt),
  .tog         (tog)
);

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctrl;
  localparam int SEC_CYC  = 80;
  localparam int CHIP_CYC = 200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        we_ni = 1'b1;
  logic        oe_ni = 1'b1;
  logic        boot_lock_i = 1'b0;
  logic [7:0]  data_o;
  logic        data_en_o;

  int checks = 0;
  int errors = 0;

  flash_erase_ctrl #(.CHIP_CYC(CHIP_CYC), .SEC_CYC(SEC_CYC)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .we_ni(we_ni), .oe_ni(oe_ni), .boot_lock_i(boot_lock_i),
    .data_o(data_o), .data_en_o(data_en_o)
  );

  always #5 clk_i = ~clk_i;

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] seed(int s, int o);
    return 8'((s << 4) | o);
  endfunction

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cycles(3);
    rst_ni = 1'b1;
    cycles(2);
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; we_ni = 1'b0;
    cycles(2);
    we_ni = 1'b1;
    cycles(2);
  endtask

  // address at the fall, different address and data before the rise
  task automatic split_write(logic [15:0] a_fall, logic [15:0] a_rise, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a_fall; data_i = 8'h00; we_ni = 1'b0;
    cycles(2);
    addr_i = a_rise; data_i = d;
    cycles(1);
    we_ni = 1'b1;
    cycles(2);
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; oe_ni = 1'b0;
    cycles(2);
    d = data_o;
    oe_ni = 1'b1;
    cycles(1);
  endtask

  task automatic unlock5();
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h5555, 8'h80);
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk_i);
    rst_ni = 1'b0; oe_ni = 1'b0;
    cycles(2);
    check("R1 en low in reset", {7'd0, data_en_o}, 8'h00);
    check("R1 data zero in reset", data_o, 8'h00);
    oe_ni = 1'b1; rst_ni = 1'b1;
    cycles(2);
    check("R1 en low with oe high", {7'd0, data_en_o}, 8'h00);
    check("R1 data zero with oe high", data_o, 8'h00);
    @(negedge clk_i); oe_ni = 1'b0; addr_i = 16'h0001;
    cycles(1);
    check("R1 en high with oe low", {7'd0, data_en_o}, 8'h01);
    oe_ni = 1'b1;
    bus_read(16'h0003, d); check("R2 seed after reset", d, seed(0, 3));
  endtask

  task automatic t_seed_map();
    logic [7:0] d;
    bus_read(16'h4002, d); check("R3 main sector 2", d, seed(2, 2));
    bus_read(16'hA001, d); check("R3 param sector 5", d, seed(5, 1));
    bus_read(16'hC003, d); check("R3 boot region 6", d, seed(6, 3));
    bus_read(16'hE002, d); check("R3 boot alias region 7", d, seed(6, 2));
  endtask

  task automatic t_sector_erase();
    logic [7:0] d, d2;
    unlock5();
    split_write(16'h4000, 16'h8000, 8'h30);
    bus_read(16'h4001, d);
    check("R11 busy bit7 and low bits", d & 8'hBF, 8'h00);
    bus_read(16'h4001, d2);
    check("R11 bit6 toggles", (d ^ d2) & 8'h40, 8'h40);
    cycles(SEC_CYC - 30);
    bus_read(16'h4001, d);
    check("R10 still busy before sector time", d[7] ? 8'h01 : 8'h00, 8'h00);
    cycles(40);
    for (int o = 0; o < 4; o++) begin
      bus_read(16'h4000 + 16'(o), d); check("R7 R6 fall sector erased", d, 8'hFF);
    end
    bus_read(16'h8002, d); check("R6 rise-time sector untouched", d, seed(4, 2));
    bus_read(16'h0001, d); check("R7 other sector untouched", d, seed(0, 1));
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h1234, 8'h55);
    bus_write(16'h5555, 8'h80);
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h0000, 8'h30);
    bus_read(16'h0001, d); check("R5 wrong step no start", d, seed(0, 1));
    unlock5();
    bus_write(16'h5555, 8'h20);
    bus_read(16'h5555, d); check("R5 wrong sixth no start", d, seed(2, 1));
    cycles(SEC_CYC + 20);
    bus_read(16'h0001, d); check("R5 sector 0 intact later", d, seed(0, 1));
    bus_read(16'h4001, d); check("R5 sector 2 intact later", d, seed(2, 1));
    unlock5();
    bus_write(16'h2000, 8'h30);
    bus_read(16'h2000, d); check("R4 full sequence starts", d & 8'h80, 8'h00);
    cycles(SEC_CYC + 10);
    bus_read(16'h2003, d); check("R4 sector 1 erased", d, 8'hFF);
  endtask

  task automatic t_chip(logic lock);
    logic [7:0] d;
    do_reset();
    boot_lock_i = lock;
    unlock5();
    bus_write(16'h5555, 8'h10);
    cycles(SEC_CYC + 20);
    bus_read(16'h0000, d);
    check("R10 chip longer than sector", d[7] ? 8'h01 : 8'h00, 8'h00);
    cycles(CHIP_CYC);
    boot_lock_i = 1'b0;
    bus_read(16'h0001, d);
    check(lock ? "R8 main erased" : "R9 main erased", d, 8'hFF);
    bus_read(16'hA003, d);
    check(lock ? "R8 param erased" : "R9 param erased", d, 8'hFF);
    bus_read(16'hC002, d);
    check(lock ? "R8 boot kept" : "R9 boot erased", d, lock ? seed(6, 2) : 8'hFF);
    bus_read(16'hE003, d);
    check(lock ? "R8 boot alias kept" : "R9 boot alias erased", d, lock ? seed(6, 3) : 8'hFF);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    do_reset();
    unlock5();
    bus_write(16'h2000, 8'h30);
    cycles(5);
    @(negedge clk_i); rst_ni = 1'b0; oe_ni = 1'b0;
    cycles(2);
    check("R2 halted outputs off", {7'd0, data_en_o}, 8'h00);
    oe_ni = 1'b1; rst_ni = 1'b1;
    cycles(1);
    bus_read(16'h2002, d); check("R2 read mode after reset", d, seed(1, 2));
    cycles(SEC_CYC + 20);
    bus_read(16'h2002, d); check("R2 erase abandoned", d, seed(1, 2));
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    do_reset();
    unlock5();
    bus_write(16'h6000, 8'h30);
    unlock5();
    bus_write(16'h5555, 8'h10);
    cycles(SEC_CYC + 10);
    bus_read(16'h6001, d); check("R10 sector 3 erased", d, 8'hFF);
    bus_read(16'h0001, d); check("R10 writes during busy ignored", d, seed(0, 1));
    cycles(CHIP_CYC);
    bus_read(16'hA000, d); check("R10 no delayed chip erase", d, seed(5, 0));
  endtask

  initial begin
    cycles(2);
    t_reset();
    t_seed_map();
    t_sector_erase();
    t_abort();
    t_chip(1'b1);
    t_chip(1'b0);
    t_reset_mid();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule